// File: doc/BRIEF.md
# PCI Target Slave Interface

This block is the target half of a PCI bus attachment for a device that exposes a small bank of 32-bit registers. It watches the shared bus, compares every address phase against two base-address windows, one in I/O space and one in memory space, and claims the cycles whose address and command both fit. For a claimed cycle it drives DEVSEL, TRDY and STOP, and it turns each completed data phase into a single read or write strobe toward an internal register file. Reads are returned from that file on the AD lines.

DEVSEL uses medium decode timing. TRDY is held back by a fixed number of wait states that depends on the space and the direction. The lowest 32 bytes of each window are a legacy area in which reads can have side effects, so bursts there are cut off after one transfer. Bursts above that area run freely, and the register offset advances one word per data phase. The block accepts a new address phase that follows the final data phase of any transaction with no idle clock in between.

Top module: `pci_target_slave`

## Requirements
- R1: A cycle is claimed only when ad_in[31:WIN_BITS] equals the matching base address in all of its upper bits and the command on cbe_n fits that space. For the I/O window the command is 4'b0010 (read) or 4'b0011 (write). For the memory window it is 4'b0110, 4'b1100 or 4'b1110 (reads), or 4'b0111 or 4'b1111 (writes).
- R2: When the address phase is sampled on clock edge k, devsel_n first goes low after edge k+1, so the master first samples it on edge k+2.
- R3: A cycle whose address misses both windows, or whose command does not fit the window it hits (configuration commands included), leaves devsel_n, trdy_n and stop_n high and produces no register strobe.
- R4: The multiple-line read (4'b1100) and line read (4'b1110) commands behave exactly like a memory read. The write-and-invalidate command (4'b1111) behaves exactly like a memory write.
- R5: In each data phase, trdy_n goes low W clocks after devsel_n is asserted (first phase) or after the previous transfer (later phases). W is 9 for memory reads, 0 for memory writes, 9 for I/O reads and 3 for I/O writes.
- R6: In a clock where irdy_n and trdy_n are both low, exactly one of reg_wr or reg_rd is high. During that clock reg_addr is the word offset inside the window, reg_be is ~cbe_n, reg_wdata is ad_in, and ad_out carries reg_rdata.
- R7: If the offset is below 32 and frame_n is still low when TRDY is asserted, stop_n goes low together with trdy_n. Exactly one transfer takes place, and devsel_n and stop_n stay low until frame_n is sampled high.
- R8: At offsets of 32 and above, a burst transfers every data phase. reg_addr advances by one word after each transfer, and the wait states of R5 are inserted again before each phase.
- R9: After the final data phase, devsel_n, trdy_n and stop_n are driven high with tgt_oe high for one clock. tgt_oe is low on the clock after that.
- R10: An address phase that arrives on the clock right after a final data phase, whether that phase belonged to this target or to another one, is decoded and claimed as usual.
- R11: fbb_capable is always 1.
- R12: During and right after reset, devsel_n, trdy_n and stop_n are high, tgt_oe and ad_oe are low, and no register strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Master cycle framing, active low |
| irdy_n | input | 1 | Master ready, active low |
| ad_in | input | 32 | Address and data lines as received |
| cbe_n | input | 4 | Command in the address phase, byte enables in data phases |
| ad_out | output | 32 | Read data returned to the master |
| ad_oe | output | 1 | Enables the AD drivers during a claimed read |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target stop request, active low |
| tgt_oe | output | 1 | Enables the DEVSEL/TRDY/STOP drivers |
| fbb_capable | output | 1 | Fast back-to-back capability flag |
| reg_addr | output | WIN_BITS-2 | Word offset into the register file |
| reg_be | output | 4 | Active-high byte enables for the access |
| reg_wdata | output | 32 | Write data toward the register file |
| reg_wr | output | 1 | One-clock write strobe |
| reg_rd | output | 1 | One-clock read strobe |
| reg_rdata | input | 32 | Read data from the register file |

## Verification
The main decode is tried with every accepted command in both windows and with commands that fit the other window. It is also tried with a configuration command, an address just past the window, and an address that differs only in bit 31. Together these separate a correct full-width compare from a partial one, and correct command filtering from aliasing. Single, burst and legacy-area transfers are driven in each direction and each space. Their DEVSEL and TRDY arrival times tell the four wait-state settings apart, and the transfer counts show whether STOP is raised inside the legacy area and withheld above it. Back-to-back sequences, one after the same target and one after a foreign cycle, show whether an address phase is missed while the target is still releasing its signals.

// File: rtl/pci_target_slave.sv
module pci_target_slave #(
  parameter logic [31:0] IO_BASE      = 32'h0000_C000,
  parameter logic [31:0] MEM_BASE     = 32'hFEB0_0000,
  parameter int          WIN_BITS     = 8,
  parameter int          LEGACY_BYTES = 32,
  parameter int          MEM_RD_WAIT  = 9,
  parameter int          MEM_WR_WAIT  = 0,
  parameter int          IO_RD_WAIT   = 9,
  parameter int          IO_WR_WAIT   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_n,
  input  logic                irdy_n,
  input  logic [31:0]         ad_in,
  input  logic [3:0]          cbe_n,
  output logic [31:0]         ad_out,
  output logic                ad_oe,
  output logic                devsel_n,
  output logic                trdy_n,
  output logic                stop_n,
  output logic                tgt_oe,
  output logic                fbb_capable,
  output logic [WIN_BITS-3:0] reg_addr,
  output logic [3:0]          reg_be,
  output logic [31:0]         reg_wdata,
  output logic                reg_wr,
  output logic                reg_rd,
  input  logic [31:0]         reg_rdata
);

  localparam int WORD_W = WIN_BITS - 2;
  localparam int MAXW_A = (MEM_RD_WAIT > MEM_WR_WAIT) ? MEM_RD_WAIT : MEM_WR_WAIT;
  localparam int MAXW_B = (IO_RD_WAIT > IO_WR_WAIT) ? IO_RD_WAIT : IO_WR_WAIT;
  localparam int MAXW   = (MAXW_A > MAXW_B) ? MAXW_A : MAXW_B;
  localparam int CNT_W  = $clog2(MAXW + 1) < 1 ? 1 : $clog2(MAXW + 1);
  localparam logic [WIN_BITS-1:0] LEGACY_LIM = WIN_BITS'(LEGACY_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_DEC, S_DATA, S_DRAIN, S_TURN} st_t;

  st_t                 st;
  logic                frame_q;
  logic [WIN_BITS-1:0] off;
  logic                wr_q;
  logic [CNT_W-1:0]    wlen, wcnt;
  logic                dev_q, rdy_q, stp_q;

  // address decode on the raw bus
  logic io_hit, mem_hit, io_rd, io_wr, mem_rd, mem_wr, claim, cmd_wr, addr_phase;
  logic [CNT_W-1:0] wsel;

  assign io_hit  = ad_in[31:WIN_BITS] == IO_BASE[31:WIN_BITS];
  assign mem_hit = ad_in[31:WIN_BITS] == MEM_BASE[31:WIN_BITS];
  assign io_rd   = cbe_n == 4'b0010;
  assign io_wr   = cbe_n == 4'b0011;
  assign mem_rd  = cbe_n == 4'b0110 || cbe_n == 4'b1100 || cbe_n == 4'b1110;
  assign mem_wr  = cbe_n == 4'b0111 || cbe_n == 4'b1111;
  assign claim   = (io_hit && (io_rd || io_wr)) || (mem_hit && (mem_rd || mem_wr));
  assign cmd_wr  = io_wr || mem_wr;
  assign wsel    = io_hit ? (io_wr  ? CNT_W'(IO_WR_WAIT)  : CNT_W'(IO_RD_WAIT))
                          : (mem_wr ? CNT_W'(MEM_WR_WAIT) : CNT_W'(MEM_RD_WAIT));

  assign addr_phase = frame_q && !frame_n && (st == S_IDLE || st == S_TURN);

  logic xfer, low_win;
  assign xfer    = st == S_DATA && rdy_q && !irdy_n;
  assign low_win = off < LEGACY_LIM;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      frame_q <= 1'b1;
      off     <= '0;
      wr_q    <= 1'b0;
      wlen    <= '0;
      wcnt    <= '0;
      dev_q   <= 1'b0;
      rdy_q   <= 1'b0;
      stp_q   <= 1'b0;
    end else begin
      frame_q <= frame_n;
      case (st)
        S_IDLE, S_TURN: begin
          dev_q <= 1'b0;
          rdy_q <= 1'b0;
          stp_q <= 1'b0;
          if (addr_phase && claim) begin
            st   <= S_DEC;
            off  <= ad_in[WIN_BITS-1:0];
            wr_q <= cmd_wr;
            wlen <= wsel;
          end else begin
            st <= S_IDLE;
          end
        end
        S_DEC: begin
          st    <= S_DATA;
          dev_q <= 1'b1;
          wcnt  <= wlen;
          if (wlen == '0) begin
            rdy_q <= 1'b1;
            stp_q <= low_win && !frame_n;
          end
        end
        S_DATA: begin
          if (xfer) begin
            if (frame_n) begin
              st    <= S_TURN;
              dev_q <= 1'b0;
              rdy_q <= 1'b0;
              stp_q <= 1'b0;
            end else if (stp_q) begin
              st    <= S_DRAIN;
              rdy_q <= 1'b0;
            end else begin
              off   <= off + WIN_BITS'(4);
              wcnt  <= wlen;
              rdy_q <= wlen == '0;
            end
          end else if (!rdy_q) begin
            if (wcnt == CNT_W'(1)) begin
              rdy_q <= 1'b1;
              stp_q <= low_win && !frame_n;
            end
            if (wcnt != '0) wcnt <= wcnt - CNT_W'(1);
          end
        end
        S_DRAIN: begin
          if (frame_n) begin
            st    <= S_TURN;
            dev_q <= 1'b0;
            stp_q <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign devsel_n    = !dev_q;
  assign trdy_n      = !rdy_q;
  assign stop_n      = !stp_q;
  assign tgt_oe      = st == S_DATA || st == S_DRAIN || st == S_TURN;
  assign ad_oe       = !wr_q && (st == S_DATA || st == S_DRAIN);
  assign ad_out      = reg_rdata;
  assign fbb_capable = 1'b1;
  assign reg_addr    = off[WIN_BITS-1:2];
  assign reg_be      = ~cbe_n;
  assign reg_wdata   = ad_in;
  assign reg_wr      = xfer && wr_q;
  assign reg_rd      = xfer && !wr_q;

  assert_medium_devsel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> $past(addr_phase, 2));

  assert_reject_no_devsel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase && !claim) |=> ##1 devsel_n);

  assert_trdy_needs_devsel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);

  assert_strobe_on_handshake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |-> (!devsel_n && !trdy_n && !irdy_n && tgt_oe));

  assert_stop_only_legacy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_n) |-> (reg_addr < WORD_W'(LEGACY_BYTES / 4)));

  assert_burst_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_wr || reg_rd) && !frame_n && stop_n) |=> (reg_addr == WORD_W'($past(reg_addr) + 1'b1)));

  assert_release_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tgt_oe) |-> $past(devsel_n && trdy_n && stop_n));

endmodule

// File: tb/pci_target_slave_test.sv
module pci_target_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IOB  = 32'h0000_C000;
  localparam logic [31:0] MEMB = 32'hFEB0_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_out, reg_wdata, reg_rdata;
  logic ad_oe, devsel_n, trdy_n, stop_n, tgt_oe, fbb_capable, reg_wr, reg_rd;
  logic [5:0] reg_addr;
  logic [3:0] reg_be;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pci_target_slave #(.IO_BASE(IOB), .MEM_BASE(MEMB)) uut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .ad_in(ad_in),
    .cbe_n(cbe_n), .ad_out(ad_out), .ad_oe(ad_oe), .devsel_n(devsel_n), .trdy_n(trdy_n),
    .stop_n(stop_n), .tgt_oe(tgt_oe), .fbb_capable(fbb_capable), .reg_addr(reg_addr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata));

  // register file model behind the target
  logic [31:0] regs [64];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) regs[i] <= 32'h1000_0000 + 32'(i);
    end else if (reg_wr) begin
      for (int b = 0; b < 4; b++)
        if (reg_be[b]) regs[reg_addr][8*b +: 8] <= reg_wdata[8*b +: 8];
    end
  end
  assign reg_rdata = regs[reg_addr];

  logic [31:0] expm [64];
  int checks = 0, fails = 0;
  bit done = 0;

  int r_fdev, r_ftrdy, r_nx, r_gap, r_last, r_aerr;
  bit r_stp;
  logic [31:0] r_rd0;
  logic [3:0]  r_be;

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  cmd;
    logic [3:0]  nph;
    logic        claim;
    logic [3:0]  w;
    logic        stp;
    logic [3:0]  nx;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{MEMB + 32'h40, 4'b0111, 4'd1, 1'b1, 4'd0, 1'b0, 4'd1},
    '{MEMB + 32'h40, 4'b0110, 4'd1, 1'b1, 4'd9, 1'b0, 4'd1},
    '{IOB  + 32'h44, 4'b0011, 4'd1, 1'b1, 4'd3, 1'b0, 4'd1},
    '{IOB  + 32'h44, 4'b0010, 4'd1, 1'b1, 4'd9, 1'b0, 4'd1},
    '{MEMB + 32'h80, 4'b0111, 4'd3, 1'b1, 4'd0, 1'b0, 4'd3},
    '{MEMB + 32'h80, 4'b1110, 4'd2, 1'b1, 4'd9, 1'b0, 4'd2},
    '{MEMB + 32'h84, 4'b1100, 4'd1, 1'b1, 4'd9, 1'b0, 4'd1},
    '{MEMB + 32'h48, 4'b1111, 4'd1, 1'b1, 4'd0, 1'b0, 4'd1},
    '{MEMB + 32'h08, 4'b0111, 4'd3, 1'b1, 4'd0, 1'b1, 4'd1},
    '{IOB  + 32'h10, 4'b0011, 4'd2, 1'b1, 4'd3, 1'b1, 4'd1},
    '{MEMB + 32'h40, 4'b0010, 4'd1, 1'b0, 4'd0, 1'b0, 4'd0},
    '{IOB  + 32'h44, 4'b0110, 4'd1, 1'b0, 4'd0, 1'b0, 4'd0},
    '{MEMB + 32'h100, 4'b0110, 4'd1, 1'b0, 4'd0, 1'b0, 4'd0},
    '{(MEMB ^ 32'h8000_0000) + 32'h40, 4'b0110, 4'd1, 1'b0, 4'd0, 1'b0, 4'd0},
    '{MEMB + 32'h40, 4'b1010, 4'd1, 1'b0, 4'd0, 1'b0, 4'd0},
    '{IOB  + 32'h20, 4'b0011, 4'd2, 1'b1, 4'd3, 1'b0, 4'd2},
    '{MEMB + 32'h1C, 4'b0110, 4'd1, 1'b1, 4'd9, 1'b0, 4'd1},
    '{MEMB + 32'h88, 4'b0110, 4'd1, 1'b1, 4'd9, 1'b0, 4'd1}
  };

  function automatic logic [31:0] wd(input logic [31:0] a, input int k);
    return (32'hA500_0000 ^ a) + 32'(k);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // one master transaction, starting at a falling clock edge
  task automatic xact(input logic [31:0] addr, input logic [3:0] cmd,
                      input logic [3:0] ben, input int nph);
    bit xf_now, end_now;
    r_fdev = -1; r_ftrdy = -1; r_nx = 0; r_gap = 0; r_last = -1; r_aerr = 0;
    r_stp = 0; r_rd0 = '0; r_be = '0;
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
    @(negedge clk);
    frame_n = (nph == 1); irdy_n = 1'b0; cbe_n = ben; ad_in = wd(addr, 0);
    for (int i = 0; i < 40; i++) begin
      #1;
      if (!devsel_n && r_fdev < 0) r_fdev = i;
      if (!trdy_n && r_ftrdy < 0) r_ftrdy = i;
      if (!stop_n) r_stp = 1;
      xf_now  = !trdy_n;
      end_now = frame_n && (!trdy_n || !stop_n);
      if (reg_wr || reg_rd) begin
        if (reg_addr != 6'(addr[7:2] + 6'(r_nx))) r_aerr++;
        r_be = reg_be;
      end
      if (xf_now) begin
        if (r_nx == 0) r_rd0 = ad_out;
        if (r_last >= 0) r_gap = i - r_last;
        r_last = i;
        r_nx++;
      end
      @(negedge clk);
      if (end_now || (devsel_n && i >= 5)) break;
      if (xf_now && !frame_n) begin
        ad_in = wd(addr, r_nx);
        if (r_nx == nph - 1 || !stop_n) frame_n = 1'b1;
      end else if (!stop_n) begin
        frame_n = 1'b1;
      end
    end
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF; ad_in = '0;
    if (r_fdev >= 0) begin
      #1;
      chk("R9 release clock drives high", {devsel_n, trdy_n, stop_n, tgt_oe}, 4'b1111);
    end
  endtask

  // another target's single cycle: address, then one final data phase
  task automatic foreign();
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = 32'h1234_5600; cbe_n = 4'b0111;
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b0; cbe_n = 4'h0; ad_in = 32'hDEAD_BEEF;
    @(negedge clk);
    irdy_n = 1'b1; cbe_n = 4'hF;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 64; i++) expm[i] = 32'h1000_0000 + 32'(i);
    repeat (3) @(negedge clk);
    #1;
    chk("R12 outputs in reset", {devsel_n, trdy_n, stop_n, tgt_oe, ad_oe, reg_wr, reg_rd}, 7'b1110000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R12 outputs after reset", {devsel_n, trdy_n, stop_n, tgt_oe, ad_oe, reg_wr, reg_rd}, 7'b1110000);
    chk("R11 fast back-to-back flag", fbb_capable, 1'b1);
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [5:0] idx;
      bit alias_cmd;
      idx = VEC[v].addr[7:2];
      alias_cmd = VEC[v].cmd inside {4'b1100, 4'b1110, 4'b1111};
      xact(VEC[v].addr, VEC[v].cmd, 4'h0, int'(VEC[v].nph));
      chk("R1 claim decision", r_fdev >= 0, VEC[v].claim);
      if (VEC[v].claim) begin
        chk("R2 devsel arrival", r_fdev, 1);
        chk(alias_cmd ? "R4 aliased wait states" : "R5 wait states", r_ftrdy - r_fdev, VEC[v].w);
        chk("R7 stop signalled", r_stp, VEC[v].stp);
        chk("R7 transfer count", r_nx, VEC[v].nx);
        chk("R6 register offset", r_aerr, 0);
        if (r_nx > 1) chk("R8 per-phase wait", r_gap, VEC[v].w + 1);
        if (!VEC[v].cmd[0]) chk(alias_cmd ? "R4 aliased read data" : "R6 read data", r_rd0, expm[idx]);
        else for (int k = 0; k < r_nx; k++) expm[idx + 6'(k)] = wd(VEC[v].addr, k);
      end else begin
        chk("R3 rejected cycle strobes", r_nx, 0);
      end
      @(negedge clk);
    end

    // R9: drivers released one clock after the release clock
    xact(MEMB + 32'h4C, 4'b0111, 4'h0, 1);
    @(negedge clk);
    #1;
    chk("R9 drivers released", tgt_oe, 1'b0);
    @(negedge clk);

    // R10: same-target back-to-back, write then read with no idle clock
    xact(MEMB + 32'h50, 4'b0111, 4'h0, 1);
    xact(MEMB + 32'h50, 4'b0110, 4'h0, 1);
    chk("R10 back-to-back claim", r_fdev, 1);
    chk("R10 back-to-back read data", r_rd0, wd(MEMB + 32'h50, 0));
    @(negedge clk);

    // R10: cycle to another target immediately followed by ours
    foreign();
    xact(IOB + 32'h54, 4'b0011, 4'h0, 1);
    chk("R10 claim after foreign cycle", r_fdev, 1);
    chk("R10 transfer after foreign cycle", r_nx, 1);
    @(negedge clk);

    // R6: partial byte enables, low half only
    xact(MEMB + 32'h58, 4'b0111, 4'b1100, 1);
    chk("R6 byte enables", r_be, 4'b0011);
    @(negedge clk);
    xact(MEMB + 32'h58, 4'b0110, 4'h0, 1);
    chk("R6 partial write merge", r_rd0, {expm[22][31:16], wd(MEMB + 32'h58, 0)[15:0]});
    @(negedge clk);

    finish_up();
  end
endmodule